// File: doc/BRIEF.md
# Core Wrapper Serial Test Logic

This block is the serial test shell placed around an embedded core. One serial input and one serial output carry test data. Separate control inputs apply the operations directly: a wrapper clock, an active-low reset, an instruction-path select, and enables for capture, shift, update and transfer. No sequencing machine sits between the controls and the registers. Each operation acts on the rising clock edge while its enable is high, so one operation can follow another on the next edge.

Inside there is a 3-bit instruction register, a one-bit bypass register and a boundary register. The boundary register is a chain of cells, one per core input and one per core output. Each cell has a shift stage, which is on the serial path, and a hold stage, which is off it. A cell drives its output in one of three ways: it passes its functional input through, it drives its hold value, or it drives a fixed safe value. The current instruction picks the drive of every cell, which register lies on the serial path, and where a capture takes its data from. The block can isolate the core, test the board wiring around it, test the core from its own boundary, preload values, clamp the pins, or park every boundary signal at a harmless level.

Top module: `wsl_wrapper`

## Requirements
- R1: While `wrst_n` is low, the instruction becomes bypass, the bypass register and all shift and hold stages clear to 0, `so` reads 0, `core_in` equals `pin_in` and `pin_out` equals `core_out`.
- R2: While `sel_ir` is high, the instruction shift register lies on the serial path. It shifts right on `shift_en`, taking `si` into its top bit, and `so` shows its bit 0. A capture loads it with 3'b001.
- R3: The instruction changes only on an edge where both `sel_ir` and `upd_en` are high. It then loads the instruction shift register. Shifting alone, or an update with `sel_ir` low, leaves the instruction and every output unchanged.
- R4: The instruction codes are 0 bypass, 1 external test, 2 internal test, 3 preload, 4 clamp and 5 safe. Codes 6 and 7 behave exactly as bypass: functional pass-through, with the bypass register on the path.
- R5: Under bypass, clamp, safe and the unused codes, with `sel_ir` low, the bypass register is on the path. `so` gives `si` delayed by one shift edge, and a capture loads 0.
- R6: Under external test, internal test and preload, with `sel_ir` low, the boundary register is on the path. The input cells come first (cell i maps to `pin_in[i]`), then the output cells (cell N_IN+j maps to `pin_out[j]`). `si` enters cell 0 and `so` shows the last cell, so the path is N_IN+N_OUT bits long.
- R7: A shift leaves `core_in` and `pin_out` unchanged. An update on the boundary register copies every shift stage into its hold stage, and the outputs that drive hold values change on that same edge.
- R8: Under external test, `pin_out` drives the output cells' hold values and `core_in` drives SAFE_IN (default 4'h3). A capture loads the input cells from `pin_in` and the output cells from the value they drive on `pin_out`.
- R9: Under internal test, `core_in` drives the input cells' hold values and `pin_out` drives SAFE_OUT (default 4'hC). A capture loads the input cells from the value they drive into the core and the output cells from `core_out`.
- R10: Under preload, both sides pass their functional inputs through and capture has no effect on the boundary register. Shift and update act on it as usual.
- R11: Under clamp, both `core_in` and `pin_out` drive the hold values. An update does not alter those hold values.
- R12: Under safe, `core_in` is SAFE_IN and `pin_out` is SAFE_OUT, whatever the functional inputs are.
- R13: A transfer on the boundary register loads every shift stage from its own hold stage. Capture has priority over shift, and shift has priority over transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Wrapper clock; every operation acts on its rising edge |
| wrst_n | input | 1 | Asynchronous active-low wrapper reset |
| si | input | 1 | Serial test data input |
| so | output | 1 | Serial test data output from the selected register |
| sel_ir | input | 1 | Selects the instruction register for the serial path |
| cap_en | input | 1 | Capture enable |
| shift_en | input | 1 | Shift enable |
| upd_en | input | 1 | Update enable |
| xfer_en | input | 1 | Transfer enable |
| pin_in | input | N_IN | Functional inputs arriving from outside the core |
| core_in | output | N_IN | Inputs delivered to the core |
| core_out | input | N_OUT | Results produced by the core |
| pin_out | output | N_OUT | Outputs driven outside the core |

## Verification
The bench aims at the following corner cases:
- The direct-control rules. An instruction shifted in without the update, or an update with the instruction path deselected, must leave the mode as it is. A design that loaded the instruction early would switch out of clamp and show pass-through values.
- The capture source in the two test modes. Under external test the output cells capture what they drive on the pins; under internal test the input cells capture what they drive into the core. A swapped source reads back as the wrong byte.
- Capture under preload. It must be ignored, so the preloaded pattern reads back intact.
- Transfer. The hold contents must come back out serially after the shift stages were filled with ones.
- The unused codes. They must act as bypass, so a design that gave them another mode would drive safe or hold values.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_BYPASS  = 3'd0;
   localparam logic [OP_W-1:0] OP_EXTEST  = 3'd1;
   localparam logic [OP_W-1:0] OP_INTEST  = 3'd2;
   localparam logic [OP_W-1:0] OP_PRELOAD = 3'd3;
   localparam logic [OP_W-1:0] OP_CLAMP   = 3'd4;
   localparam logic [OP_W-1:0] OP_SAFE    = 3'd5;

   localparam logic [OP_W-1:0] IR_CAPTURE = 3'b001;

   typedef enum logic [1:0] {
      DRV_PASS = 2'd0,
      DRV_HOLD = 2'd1,
      DRV_SAFE = 2'd2
   } drive_e;

   typedef struct packed {
      logic   bnd_sel;
      logic   cap_ok;
      drive_e in_drv;
      drive_e out_drv;
      logic   in_cap_fo;
      logic   out_cap_fo;
   } ctl_t;

   function automatic ctl_t decode_op(input logic [OP_W-1:0] code);
      ctl_t c;
      c.bnd_sel    = 1'b0;
      c.cap_ok     = 1'b0;
      c.in_drv     = DRV_PASS;
      c.out_drv    = DRV_PASS;
      c.in_cap_fo  = 1'b0;
      c.out_cap_fo = 1'b0;
      case (code)
         OP_EXTEST: begin
            c.bnd_sel    = 1'b1;
            c.cap_ok     = 1'b1;
            c.in_drv     = DRV_SAFE;
            c.out_drv    = DRV_HOLD;
            c.out_cap_fo = 1'b1;
         end
         OP_INTEST: begin
            c.bnd_sel   = 1'b1;
            c.cap_ok    = 1'b1;
            c.in_drv    = DRV_HOLD;
            c.out_drv   = DRV_SAFE;
            c.in_cap_fo = 1'b1;
         end
         OP_PRELOAD: begin
            c.bnd_sel = 1'b1;
         end
         OP_CLAMP: begin
            c.in_drv  = DRV_HOLD;
            c.out_drv = DRV_HOLD;
         end
         OP_SAFE: begin
            c.in_drv  = DRV_SAFE;
            c.out_drv = DRV_SAFE;
         end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/wsl_instr_reg.sv
module wsl_instr_reg #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   input  logic         cap,
   input  logic         shift,
   input  logic         upd,
   input  logic         sin,
   output logic         sout,
   output logic [W-1:0] op
);
   import wsl_pkg::*;

   logic [W-1:0] shreg;

   if (W < OP_W) begin : g_bad_width
      $error("wsl_instr_reg: W must be at least %0d", OP_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (sel && cap) begin
         shreg <= W'(IR_CAPTURE);
      end else if (sel && shift) begin
         shreg <= {sin, shreg[W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op <= W'(OP_BYPASS);
      end else if (sel && upd) begin
         op <= shreg;
      end
   end

   assign sout = shreg[0];

endmodule

// File: rtl/wsl_bypass.sv
module wsl_bypass (
   input  logic clk,
   input  logic rst_n,
   input  logic cap,
   input  logic shift,
   input  logic sin,
   output logic sout
);

   logic bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
      end else if (cap) begin
         bit_q <= 1'b0;
      end else if (shift) begin
         bit_q <= sin;
      end
   end

   assign sout = bit_q;

endmodule

// File: rtl/wsl_bcell.sv
module wsl_bcell #(
   parameter logic SAFE_V = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tst_i,
   output logic            tst_o,
   input  logic            fn_i,
   output logic            fn_o,
   input  logic            cap,
   input  logic            shift,
   input  logic            upd,
   input  logic            xfer,
   input  logic            cap_fo,
   input  wsl_pkg::drive_e drv
);
   import wsl_pkg::*;

   logic sh_q;
   logic hold_q;

   // capture wins over shift, shift wins over transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= 1'b0;
      end else if (cap) begin
         sh_q <= cap_fo ? fn_o : fn_i;
      end else if (shift) begin
         sh_q <= tst_i;
      end else if (xfer) begin
         sh_q <= hold_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (upd) begin
         hold_q <= sh_q;
      end
   end

   always_comb begin
      case (drv)
         DRV_HOLD: fn_o = hold_q;
         DRV_SAFE: fn_o = SAFE_V;
         default:  fn_o = fn_i;
      endcase
   end

   assign tst_o = sh_q;

endmodule

// File: rtl/wsl_bnd_reg.sv
module wsl_bnd_reg #(
   parameter int               N_IN     = 4,
   parameter int               N_OUT    = 4,
   parameter logic [N_IN-1:0]  SAFE_IN  = 4'h3,
   parameter logic [N_OUT-1:0] SAFE_OUT = 4'hC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sin,
   output logic               sout,
   input  logic               cap,
   input  logic               shift,
   input  logic               upd,
   input  logic               xfer,
   input  wsl_pkg::ctl_t      ctl,
   input  logic [N_IN-1:0]    pin_in,
   output logic [N_IN-1:0]    core_in,
   input  logic [N_OUT-1:0]   core_out,
   output logic [N_OUT-1:0]   pin_out
);
   import wsl_pkg::*;

   localparam int NC = N_IN + N_OUT;
   localparam logic [NC-1:0] SAFE_ALL = {SAFE_OUT, SAFE_IN};

   logic [NC-1:0] fi_v;
   logic [NC-1:0] fo_v;
   logic [NC-1:0] ti_v;
   logic [NC-1:0] to_v;
   logic [NC-1:0] capfo_v;
   drive_e        drv_v [NC];

   if (N_IN < 1 || N_OUT < 1) begin : g_bad_size
      $error("wsl_bnd_reg: N_IN and N_OUT must each be at least 1");
   end

   assign fi_v              = {core_out, pin_in};
   assign {pin_out, core_in} = fo_v;

   if (NC > 1) begin : g_chain
      assign ti_v = {to_v[NC-2:0], sin};
   end else begin : g_single
      assign ti_v = sin;
   end
   assign sout = to_v[NC-1];

   for (genvar i = 0; i < NC; i++) begin : g_cell
      if (i < N_IN) begin : g_in_side
         assign drv_v[i]   = ctl.in_drv;
         assign capfo_v[i] = ctl.in_cap_fo;
      end else begin : g_out_side
         assign drv_v[i]   = ctl.out_drv;
         assign capfo_v[i] = ctl.out_cap_fo;
      end

      wsl_bcell #(
         .SAFE_V (SAFE_ALL[i])
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .tst_i  (ti_v[i]),
         .tst_o  (to_v[i]),
         .fn_i   (fi_v[i]),
         .fn_o   (fo_v[i]),
         .cap    (cap),
         .shift  (shift),
         .upd    (upd),
         .xfer   (xfer),
         .cap_fo (capfo_v[i]),
         .drv    (drv_v[i])
      );
   end

endmodule

// File: rtl/wsl_wrapper.sv
module wsl_wrapper #(
   parameter int               N_IN     = 4,
   parameter int               N_OUT    = 4,
   parameter int               IR_W     = 3,
   parameter logic [N_IN-1:0]  SAFE_IN  = 4'h3,
   parameter logic [N_OUT-1:0] SAFE_OUT = 4'hC
) (
   input  logic             wclk,
   input  logic             wrst_n,
   input  logic             si,
   output logic             so,
   input  logic             sel_ir,
   input  logic             cap_en,
   input  logic             shift_en,
   input  logic             upd_en,
   input  logic             xfer_en,
   input  logic [N_IN-1:0]  pin_in,
   output logic [N_IN-1:0]  core_in,
   input  logic [N_OUT-1:0] core_out,
   output logic [N_OUT-1:0] pin_out
);
   import wsl_pkg::*;

   logic [IR_W-1:0] cur_op;
   logic [OP_W-1:0] eff_code;
   ctl_t            ctl;
   logic            ir_so;
   logic            by_so;
   logic            bnd_so;
   logic            dr_path;

   if (IR_W < OP_W) begin : g_bad_ir
      $error("wsl_wrapper: IR_W must be at least %0d", OP_W);
   end

   wsl_instr_reg #(
      .W (IR_W)
   ) u_ir (
      .clk   (wclk),
      .rst_n (wrst_n),
      .sel   (sel_ir),
      .cap   (cap_en),
      .shift (shift_en),
      .upd   (upd_en),
      .sin   (si),
      .sout  (ir_so),
      .op    (cur_op)
   );

   // codes wider than the defined set fall back to bypass
   if (IR_W > OP_W) begin : g_wide_code
      assign eff_code = (cur_op[IR_W-1:OP_W] == '0) ? cur_op[OP_W-1:0] : OP_BYPASS;
   end else begin : g_exact_code
      assign eff_code = cur_op[OP_W-1:0];
   end

   assign ctl     = decode_op(eff_code);
   assign dr_path = !sel_ir;

   wsl_bypass u_by (
      .clk   (wclk),
      .rst_n (wrst_n),
      .cap   (dr_path && cap_en && !ctl.bnd_sel),
      .shift (dr_path && shift_en && !ctl.bnd_sel),
      .sin   (si),
      .sout  (by_so)
   );

   wsl_bnd_reg #(
      .N_IN     (N_IN),
      .N_OUT    (N_OUT),
      .SAFE_IN  (SAFE_IN),
      .SAFE_OUT (SAFE_OUT)
   ) u_bnd (
      .clk      (wclk),
      .rst_n    (wrst_n),
      .sin      (si),
      .sout     (bnd_so),
      .cap      (dr_path && cap_en && ctl.bnd_sel && ctl.cap_ok),
      .shift    (dr_path && shift_en && ctl.bnd_sel),
      .upd      (dr_path && upd_en && ctl.bnd_sel),
      .xfer     (dr_path && xfer_en && ctl.bnd_sel),
      .ctl      (ctl),
      .pin_in   (pin_in),
      .core_in  (core_in),
      .core_out (core_out),
      .pin_out  (pin_out)
   );

   always_comb begin
      if (sel_ir)           so = ir_so;
      else if (ctl.bnd_sel) so = bnd_so;
      else                  so = by_so;
   end

endmodule

// File: rtl/wsl_wrapper_chk.sv
module wsl_wrapper_chk #(
   parameter int               N_IN     = 4,
   parameter int               N_OUT    = 4,
   parameter logic [N_IN-1:0]  SAFE_IN  = 4'h3,
   parameter logic [N_OUT-1:0] SAFE_OUT = 4'hC
) (
   input logic             wclk,
   input logic             wrst_n,
   input logic             sel_ir,
   input logic             shift_en,
   input logic             upd_en,
   input logic             si,
   input logic             so,
   input logic [2:0]       eff_code,
   input logic [N_IN-1:0]  pin_in,
   input logic [N_IN-1:0]  core_in,
   input logic [N_OUT-1:0] core_out,
   input logic [N_OUT-1:0] pin_out
);
   import wsl_pkg::*;

   logic by_path;
   logic pass_mode;

   assign by_path   = eff_code inside {OP_BYPASS, OP_CLAMP, OP_SAFE, 3'd6, 3'd7};
   assign pass_mode = eff_code inside {OP_BYPASS, 3'd6, 3'd7};

   // R5: one-bit delay through the bypass register
   a_r5_bypass_delay: assert property (@(posedge wclk) disable iff (!wrst_n)
      (!sel_ir && shift_en && by_path) |=> (sel_ir || so == $past(si)));

   // R3: the instruction moves only on update with the instruction path selected
   a_r3_instr_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
      !(sel_ir && upd_en) |=> $stable(eff_code));

   // R4: bypass and unused codes pass functional data through
   a_r4_pass_through: assert property (@(posedge wclk) disable iff (!wrst_n)
      pass_mode |-> (core_in == pin_in && pin_out == core_out));

   // R12: safe mode parks every boundary output
   a_r12_safe_values: assert property (@(posedge wclk) disable iff (!wrst_n)
      (eff_code == OP_SAFE) |-> (core_in == SAFE_IN && pin_out == SAFE_OUT));

   // R11: clamp keeps both sides steady while it lasts
   a_r11_clamp_steady: assert property (@(posedge wclk) disable iff (!wrst_n)
      (eff_code == OP_CLAMP && $past(eff_code) == OP_CLAMP)
         |-> ($stable(core_in) && $stable(pin_out)));

endmodule

bind wsl_wrapper wsl_wrapper_chk #(
   .N_IN     (N_IN),
   .N_OUT    (N_OUT),
   .SAFE_IN  (SAFE_IN),
   .SAFE_OUT (SAFE_OUT)
) u_chk (
   .wclk     (wclk),
   .wrst_n   (wrst_n),
   .sel_ir   (sel_ir),
   .shift_en (shift_en),
   .upd_en   (upd_en),
   .si       (si),
   .so       (so),
   .eff_code (eff_code),
   .pin_in   (pin_in),
   .core_in  (core_in),
   .core_out (core_out),
   .pin_out  (pin_out)
);

// File: tb/wsl_wrapper_tb.sv
`timescale 1ns/1ps
module wsl_wrapper_tb;

   logic       wclk = 1'b0;
   logic       wrst_n;
   logic       si, sel_ir, cap_en, shift_en, upd_en, xfer_en;
   logic       so;
   logic [3:0] pin_in, core_in, core_out, pin_out;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2.5 wclk = ~wclk;

   wsl_wrapper u_dut (
      .wclk     (wclk),
      .wrst_n   (wrst_n),
      .si       (si),
      .so       (so),
      .sel_ir   (sel_ir),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .xfer_en  (xfer_en),
      .pin_in   (pin_in),
      .core_in  (core_in),
      .core_out (core_out),
      .pin_out  (pin_out)
   );

   // {spare, code[2:0], expected core_in, expected pin_out}
   // with pin_in = 9, core_out = 6, hold = 8'hA5, safe = 3 / C
   localparam logic [11:0] VEC [8] = '{
      12'h096, 12'h13A, 12'h25C, 12'h396,
      12'h45A, 12'h53C, 12'h696, 12'h796
   };

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int k = 0; k < 8; k++) rev8[k] = v[7-k];
   endfunction

   function automatic string row_tag(input logic [2:0] c);
      case (c)
         3'd1:    return "R8";
         3'd2:    return "R9";
         3'd3:    return "R10";
         3'd4:    return "R11";
         3'd5:    return "R12";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge wclk);
      @(negedge wclk);
   endtask

   task automatic ir_load(input logic [2:0] code);
      sel_ir   = 1'b1;
      shift_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         si = code[k];
         tick();
      end
      shift_en = 1'b0;
      upd_en   = 1'b1;
      tick();
      upd_en = 1'b0;
      sel_ir = 1'b0;
      #1;
   endtask

   task automatic dr_shift(input logic [7:0] din, output logic [7:0] dout);
      sel_ir   = 1'b0;
      shift_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
         si = din[k];
         #1 dout[k] = so;
         tick();
      end
      shift_en = 1'b0;
      #1;
   endtask

   task automatic pulse_cap();  cap_en  = 1'b1; tick(); cap_en  = 1'b0; #1; endtask
   task automatic pulse_upd();  upd_en  = 1'b1; tick(); upd_en  = 1'b0; #1; endtask
   task automatic pulse_xfer(); xfer_en = 1'b1; tick(); xfer_en = 1'b0; #1; endtask

   initial begin
      repeat (20000) @(posedge wclk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [2:0] b3;
      wrst_n = 1'b0; si = 1'b0; sel_ir = 1'b0; cap_en = 1'b0;
      shift_en = 1'b0; upd_en = 1'b0; xfer_en = 1'b0;
      pin_in = 4'h9; core_out = 4'h6;
      repeat (3) @(negedge wclk);
      #1;
      chk("R1 so", {7'd0, so}, 8'h00);
      chk("R1 core_in", {4'h0, core_in}, 8'h09);
      chk("R1 pin_out", {4'h0, pin_out}, 8'h06);
      wrst_n = 1'b1;
      @(negedge wclk);

      // R5: one-bit delay, first bit out is the cleared bypass bit
      dr_shift(8'hB2, d);
      chk("R5 bypass delay", d, {8'hB2 << 1});

      // load hold = A5 through preload, then walk the mode table
      ir_load(3'd3);
      dr_shift(rev8(8'hA5), d);
      pulse_upd();
      chk("R10 preload pass core_in", {4'h0, core_in}, 8'h09);
      for (int r = 0; r < 8; r++) begin
         ir_load(VEC[r][10:8]);
         chk({row_tag(VEC[r][10:8]), " core_in"}, {4'h0, core_in}, {4'h0, VEC[r][7:4]});
         chk({row_tag(VEC[r][10:8]), " pin_out"}, {4'h0, pin_out}, {4'h0, VEC[r][3:0]});
      end
      // R4: unused code 7 keeps the one-bit path
      dr_shift(8'h4D, d);
      chk("R4 unused code path", {d[7:1], 1'b0}, {8'h4D << 1});

      // R8: external test capture
      ir_load(3'd1);
      pin_in = 4'hC;
      pulse_cap();
      dr_shift(8'h00, d);
      chk("R8 extest capture", d, rev8(8'hAC));
      chk("R7 shift leaves pin_out", {4'h0, pin_out}, 8'h0A);
      pulse_upd();
      chk("R7 update drives pin_out", {4'h0, pin_out}, 8'h00);
      dr_shift(rev8(8'h5A), d);
      pulse_upd();
      chk("R7 update new hold", {4'h0, pin_out}, 8'h05);

      // R13: transfer brings hold back into the shift stages
      dr_shift(8'hFF, d);
      pulse_xfer();
      dr_shift(8'h00, d);
      chk("R13 transfer readback", d, rev8(8'h5A));

      // R9: internal test drive and capture
      ir_load(3'd2);
      chk("R9 core_in hold", {4'h0, core_in}, 8'h0A);
      chk("R9 pin_out safe", {4'h0, pin_out}, 8'h0C);
      pulse_cap();
      dr_shift(8'h00, d);
      chk("R9 intest capture", d, rev8(8'h6A));

      // R10: capture ignored under preload; R6 path length
      ir_load(3'd3);
      dr_shift(rev8(8'h3C), d);
      pulse_cap();
      dr_shift(rev8(8'hC3), d);
      chk("R10 capture ignored", d, rev8(8'h3C));
      chk("R6 chain order", d[7:0], 8'h3C);
      pulse_upd();
      chk("R10 core_in pass", {4'h0, core_in}, 8'h0C);
      chk("R10 pin_out pass", {4'h0, pin_out}, 8'h06);

      // R11: clamp drives hold values, bypass on the path
      ir_load(3'd4);
      chk("R11 core_in hold", {4'h0, core_in}, 8'h03);
      chk("R11 pin_out hold", {4'h0, pin_out}, 8'h0C);
      dr_shift(8'h96, d);
      chk("R11 bypass path", {d[7:1], 1'b0}, {8'h96 << 1});
      chk("R5 last bit in", {7'd0, so}, 8'h01);
      pulse_cap();
      chk("R5 capture zero", {7'd0, so}, 8'h00);
      pulse_upd();
      chk("R11 update no effect", {core_in, pin_out}, 8'h3C);

      // R2: instruction capture pattern, LSB first
      sel_ir = 1'b1;
      pulse_cap();
      shift_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         si = 1'b0;
         #1 b3[k] = so;
         tick();
      end
      shift_en = 1'b0;
      chk("R2 ir capture", {5'd0, b3}, 8'h01);
      // R3: shifted code 000 not applied without update
      chk("R3 shift only", {core_in, pin_out}, 8'h3C);
      sel_ir = 1'b0;
      pulse_upd();
      chk("R3 update with sel low", {core_in, pin_out}, 8'h3C);
      sel_ir = 1'b1;
      pulse_upd();
      sel_ir = 1'b0;
      chk("R3 update with sel high", {core_in, pin_out}, 8'hC6);

      // R1: reset in mid-run returns to bypass pass-through
      ir_load(3'd5);
      wrst_n = 1'b0;
      #1;
      chk("R1 mid reset core_in", {4'h0, core_in}, 8'h0C);
      chk("R1 mid reset pin_out", {4'h0, pin_out}, 8'h06);
      chk("R1 mid reset so", {7'd0, so}, 8'h00);
      @(negedge wclk);
      wrst_n = 1'b1;
      @(negedge wclk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule